// File: doc/BRIEF.md
# Panel Self-Refresh Source Sequencer

This block is the source-side sequencer that lets a display pipe stop refreshing a panel that keeps its own copy of the frame. Software arms it with pulse-style commands: enable, arm and disarm of active entry, a one-frame refresh request and a disable request. The sequencer counts vertical-blank pulses to decide when the screen has been idle long enough, walks through a fixed set of numbered hardware states, and reports the current state, a transition flag and an active flag.

Some transitions run on their own. Entry settles into the active state after a fixed number of frames. Exit falls back to the inactive state the same way. A self-clearing refresh bit sends exactly one frame to the panel without leaving self-refresh. When the sequencer leaves the active state it raises a one-cycle wake request, so that the link layer can send the wake-up write to the sink. A disable request is held back until no transition is in progress.

Top module: `psr_src_fsm`

## Requirements
- R1: `cur_state` carries the state code: 0 off, 1 inactive, 2 entering, 3 active, 4 active single-frame refresh, 5 exiting. After reset it reads 0 and every flag output is low.
- R2: A pulse on `en_set` latches the enable bit on the next edge, and the state goes from 0 to 1 on the edge after that. Without an armed entry the state then stays 1 whatever vblank does.
- R3: From state 1 the state moves to 2 only when entry is armed and the vblank pulses counted since the state became 1 have reached max(6, `idle_prog`). State 2 moves to 3 after ENTRY_FRAMES further vblank pulses.
- R4: A pulse on `entry_clr` disarms entry. In state 3 or 4 the state then moves straight to 5 and never passes through 4 on the way. State 5 returns to 1 after EXIT_FRAMES vblank pulses.
- R5: `sfu_set` raises `sfu_pending`. In state 3 with the bit pending, a vblank moves the state to 4. The next vblank moves it back to 3 and clears `sfu_pending` on the same edge.
- R6: `in_trans` is high exactly while the state is 2 or 5.
- R7: `wake_req` is a one-cycle pulse that is high in the first cycle after the state has left {3,4}, and only then.
- R8: A disable request is held while `in_trans` is high. Once `in_trans` is low the state goes to 0, and the enable bit, the entry bit and `sfu_pending` are all cleared. After a new enable the state stays 1 until entry is armed again.
- R9: `active` is high exactly while the state is 3 or 4.
- R10: `entry_set` and `sfu_set` are ignored while the enable bit is clear. They leave `sfu_pending` low, and the entry arming does not take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 1 | Pulse: set the enable bit |
| entry_set | input | 1 | Pulse: arm active entry |
| entry_clr | input | 1 | Pulse: disarm active entry (request exit) |
| sfu_set | input | 1 | Pulse: request a single-frame refresh |
| dis_req | input | 1 | Pulse: request disable |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| idle_prog | input | IDLE_W | Programmed idle-frame count |
| cur_state | output | 3 | Current state code |
| in_trans | output | 1 | Transition in progress |
| active | output | 1 | Self-refresh active |
| wake_req | output | 1 | Wake-the-sink pulse |
| sfu_pending | output | 1 | Self-clearing single-frame refresh bit |

## Verification
All internal state is visible within one edge: the state register drives `cur_state`, `in_trans` and `active` directly, so a wrong next-state choice shows up on these outputs in the cycle after the edge that made it. A wrong idle or phase count is hidden until the vblank that should have ended a wait, and then shows as a state change one vblank early or late. A lost or stuck refresh bit shows on `sfu_pending`, or as a state 4 that lasts a different number of frames than one. A missed wake shows as `active` falling without a `wake_req` pulse in the same cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_ENTER = 3'd2,
    ST_LIVE  = 3'd3,
    ST_SFU   = 3'd4,
    ST_EXIT  = 3'd5
  } psr_state_e;

  // Idle frames required before entry: the programmed count, never below the floor.
  function automatic int idle_threshold(int prog, int floor_v);
    return (prog > floor_v) ? prog : floor_v;
  endfunction

  function automatic logic is_transit(psr_state_e s);
    return (s == ST_ENTER) || (s == ST_EXIT);
  endfunction

  function automatic logic is_live(psr_state_e s);
    return (s == ST_LIVE) || (s == ST_SFU);
  endfunction
endpackage

// File: rtl/psr_ctl_regs.sv
module psr_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic entry_set,
  input  logic entry_clr,
  input  logic sfu_set,
  input  logic dis_req,
  input  logic dis_go,
  input  logic sfu_done,
  output logic en_q,
  output logic entry_q,
  output logic sfu_q,
  output logic dis_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      entry_q  <= 1'b0;
      sfu_q    <= 1'b0;
      dis_pend <= 1'b0;
    end else if (dis_go) begin
      en_q     <= 1'b0;
      entry_q  <= 1'b0;
      sfu_q    <= 1'b0;
      dis_pend <= 1'b0;
    end else begin
      if (en_set) en_q <= 1'b1;
      if (entry_set && en_q) entry_q <= 1'b1;
      else if (entry_clr)    entry_q <= 1'b0;
      if (sfu_done)              sfu_q <= 1'b0;
      else if (sfu_set && en_q)  sfu_q <= 1'b1;
      if (dis_req) dis_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/psr_frame_cnt.sv
module psr_frame_cnt #(
  parameter int IDLE_W       = 4,
  parameter int IDLE_MIN     = 6,
  parameter int ENTRY_FRAMES = 2,
  parameter int EXIT_FRAMES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank,
  input  logic [IDLE_W-1:0] idle_prog,
  input  psr_pkg::psr_state_e state,
  input  logic              state_chg,
  output logic              idle_met,
  output logic              phase_done
);
  import psr_pkg::*;
  localparam int PH_MAX = (ENTRY_FRAMES > EXIT_FRAMES) ? ENTRY_FRAMES : EXIT_FRAMES;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic [IDLE_W-1:0] idle_cnt;
  logic [IDLE_W-1:0] thresh;
  logic [PH_W-1:0]   ph_cnt;
  logic [PH_W-1:0]   ph_last;

  assign thresh  = IDLE_W'(idle_threshold(int'(idle_prog), IDLE_MIN));
  assign idle_met = (idle_cnt >= thresh);
  assign ph_last = (state == ST_ENTER) ? PH_W'(ENTRY_FRAMES - 1) : PH_W'(EXIT_FRAMES - 1);
  assign phase_done = vblank && is_transit(state) && (ph_cnt == ph_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (state != ST_IDLE) begin
      idle_cnt <= '0;
    end else if (vblank && !idle_met) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state_chg) begin
      ph_cnt <= '0;
    end else if (vblank && is_transit(state)) begin
      ph_cnt <= ph_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psr_next_state.sv
module psr_next_state (
  input  psr_pkg::psr_state_e state,
  input  logic en_q,
  input  logic entry_q,
  input  logic sfu_q,
  input  logic dis_pend,
  input  logic vblank,
  input  logic idle_met,
  input  logic phase_done,
  output psr_pkg::psr_state_e state_n,
  output logic dis_go
);
  import psr_pkg::*;
  assign dis_go = dis_pend && !is_transit(state);

  always_comb begin
    state_n = state;
    if (dis_go) begin
      state_n = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   if (en_q) state_n = ST_IDLE;
        ST_IDLE:  if (entry_q && idle_met) state_n = ST_ENTER;
        ST_ENTER: if (phase_done) state_n = ST_LIVE;
        ST_LIVE:  if (!entry_q) state_n = ST_EXIT;
                  else if (sfu_q && vblank) state_n = ST_SFU;
        ST_SFU:   if (!entry_q) state_n = ST_EXIT;
                  else if (vblank) state_n = ST_LIVE;
        ST_EXIT:  if (phase_done) state_n = ST_IDLE;
        default:  state_n = ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/psr_src_fsm.sv
module psr_src_fsm #(
  parameter int IDLE_W       = 4,
  parameter int IDLE_MIN     = 6,
  parameter int ENTRY_FRAMES = 2,
  parameter int EXIT_FRAMES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic              entry_set,
  input  logic              entry_clr,
  input  logic              sfu_set,
  input  logic              dis_req,
  input  logic              vblank,
  input  logic [IDLE_W-1:0] idle_prog,
  output logic [2:0]        cur_state,
  output logic              in_trans,
  output logic              active,
  output logic              wake_req,
  output logic              sfu_pending
);
  import psr_pkg::*;

  psr_state_e state, state_n;
  logic en_q, entry_q, sfu_q, dis_pend;
  logic dis_go, idle_met, phase_done;
  logic state_chg, sfu_done, leave_live;

  assign state_chg  = (state_n != state);
  assign sfu_done   = (state == ST_SFU) && vblank;
  assign leave_live = is_live(state) && !is_live(state_n);

  psr_ctl_regs u_ctl (
    .clk, .rst_n, .en_set, .entry_set, .entry_clr, .sfu_set, .dis_req,
    .dis_go, .sfu_done, .en_q, .entry_q, .sfu_q, .dis_pend
  );

  psr_frame_cnt #(
    .IDLE_W(IDLE_W), .IDLE_MIN(IDLE_MIN),
    .ENTRY_FRAMES(ENTRY_FRAMES), .EXIT_FRAMES(EXIT_FRAMES)
  ) u_cnt (
    .clk, .rst_n, .vblank, .idle_prog, .state, .state_chg, .idle_met, .phase_done
  );

  psr_next_state u_nxt (
    .state, .en_q, .entry_q, .sfu_q, .dis_pend, .vblank, .idle_met,
    .phase_done, .state_n, .dis_go
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      wake_req <= 1'b0;
    end else begin
      state    <= state_n;
      wake_req <= leave_live;
    end
  end

  assign cur_state   = state;
  assign in_trans    = is_transit(state);
  assign active      = is_live(state);
  assign sfu_pending = sfu_q;
endmodule

// File: rtl/psr_src_chk.sv
module psr_src_chk #(
  parameter int IDLE_W   = 4,
  parameter int IDLE_MIN = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vblank,
  input logic [IDLE_W-1:0] idle_prog,
  input logic [2:0]        cur_state,
  input logic              in_trans,
  input logic              active,
  input logic              wake_req,
  input logic              sfu_pending
);
  // Own count of vblanks seen while inactive, saturating.
  logic [15:0] seen_idle;
  int          need;
  always_ff @(posedge clk) begin
    if (!rst_n || cur_state != 3'd1) seen_idle <= '0;
    else if (vblank && seen_idle != 16'hFFFF) seen_idle <= seen_idle + 1'b1;
  end
  always_comb need = (int'(idle_prog) < IDLE_MIN) ? IDLE_MIN : int'(idle_prog);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state <= 3'd5); // R1
  AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd0 |=> (cur_state == 3'd0 || cur_state == 3'd1)); // R2
  AST_IDLE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd1 |=> cur_state <= 3'd2); // R3
  AST_ENTRY_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd1 && !$past(vblank)) |=> (cur_state != 3'd2 || int'(seen_idle) >= need)); // R3
  AST_ENTER_TO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd2 |=> (cur_state == 3'd2 || cur_state == 3'd3)); // R3
  AST_EXIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd5 |=> (cur_state == 3'd5 || cur_state == 3'd1)); // R4
  AST_SFU_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cur_state == 3'd4 |-> sfu_pending); // R5
  AST_SFU_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd4 && vblank) |=> (cur_state != 3'd3 || !sfu_pending)); // R5
  AST_WAKE_ON_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> wake_req); // R7
  AST_WAKE_ONLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !active); // R7
  AST_DIS_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_trans |=> cur_state != 3'd0); // R8
endmodule

bind psr_src_fsm psr_src_chk #(.IDLE_W(IDLE_W), .IDLE_MIN(IDLE_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .vblank(vblank), .idle_prog(idle_prog),
  .cur_state(cur_state), .in_trans(in_trans), .active(active),
  .wake_req(wake_req), .sfu_pending(sfu_pending)
);

// File: tb/tb_psr_src_fsm.sv
`timescale 1ns/1ps
module tb_psr_src_fsm;
  localparam int IW = 4;
  localparam int EF = 2;
  localparam int XF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_set = 0, entry_set = 0, entry_clr = 0, sfu_set = 0, dis_req = 0, vblank = 0;
  logic [IW-1:0] idle_prog = 4'd3;
  logic [2:0] cur_state;
  logic in_trans, active, wake_req, sfu_pending;

  int tests = 0, fails = 0, cycles = 0, wakes = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psr_src_fsm #(.IDLE_W(IW), .ENTRY_FRAMES(EF), .EXIT_FRAMES(XF)) dut (.*);

  // Behavioural reference: plain integers updated once per edge.
  int m_st = 0, m_idle = 0, m_ph = 0;
  bit m_en = 0, m_ent = 0, m_sfu = 0, m_dis = 0, m_wake = 0;

  always @(posedge clk) begin
    int thr, ns;
    bit tr, go;
    if (!rst_n) begin
      m_st = 0; m_idle = 0; m_ph = 0;
      m_en = 0; m_ent = 0; m_sfu = 0; m_dis = 0; m_wake = 0;
    end else begin
      thr = (int'(idle_prog) > 6) ? int'(idle_prog) : 6;
      tr  = (m_st == 2 || m_st == 5);
      go  = m_dis && !tr;
      ns  = m_st;
      if (go) ns = 0;
      else if (m_st == 0 && m_en) ns = 1;
      else if (m_st == 1 && m_ent && m_idle >= thr) ns = 2;
      else if (m_st == 2 && vblank && m_ph == EF-1) ns = 3;
      else if ((m_st == 3 || m_st == 4) && !m_ent) ns = 5;
      else if (m_st == 3 && m_sfu && vblank) ns = 4;
      else if (m_st == 4 && vblank) ns = 3;
      else if (m_st == 5 && vblank && m_ph == XF-1) ns = 1;
      m_wake = (m_st == 3 || m_st == 4) && !(ns == 3 || ns == 4);
      if (m_st != 1) m_idle = 0;
      else if (vblank && m_idle < thr) m_idle++;
      if (ns != m_st) m_ph = 0;
      else if (tr && vblank) m_ph++;
      if (go) begin m_en = 0; m_ent = 0; m_sfu = 0; m_dis = 0; end
      else begin
        if (m_st == 4 && vblank) m_sfu = 0;
        else if (sfu_set && m_en) m_sfu = 1;
        if (entry_set && m_en) m_ent = 1;
        else if (entry_clr) m_ent = 0;
        if (en_set) m_en = 1;
        if (dis_req) m_dis = 1;
      end
      m_st = ns;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    cycles++;
    if (wake_req) wakes++;
    if (rst_n && !done) begin
      check("R1 state", int'(cur_state), m_st);
      check("R6 in_trans", int'(in_trans), int'(m_st == 2 || m_st == 5));
      check("R9 active", int'(active), int'(m_st == 3 || m_st == 4));
      check("R7 wake", int'(wake_req), int'(m_wake));
      check("R5 sfu", int'(sfu_pending), int'(m_sfu));
    end
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vblank = 1'b1;
      @(negedge clk); vblank = 1'b0;
      idle(2);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset state", int'(cur_state), 0);
    check("R1 reset flags", int'({in_trans, active, wake_req, sfu_pending}), 0);
    // R10: arming and refresh ignored while not enabled
    pulse(entry_set); pulse(sfu_set); idle(2);
    check("R10 sfu ignored", int'(sfu_pending), 0);
    pulse(en_set); idle(2);
    check("R2 enable to inactive", int'(cur_state), 1);
    frames(8);
    check("R10 entry ignored stays inactive", int'(cur_state), 1);
    pulse(entry_set); idle(2);
    check("R3 enters after idle", int'(cur_state), 2);
    check("R6 in_trans entering", int'(in_trans), 1);
    frames(1);
    check("R3 still entering", int'(cur_state), 2);
    frames(1);
    check("R3 reaches active", int'(cur_state), 3);
    check("R9 active high", int'(active), 1);
    pulse(sfu_set); idle(1);
    check("R5 sfu pending", int'(sfu_pending), 1);
    frames(1);
    check("R5 single frame state", int'(cur_state), 4);
    check("R9 active in refresh", int'(active), 1);
    frames(1);
    check("R5 back to active", int'(cur_state), 3);
    check("R5 sfu self clear", int'(sfu_pending), 0);
    wakes = 0;
    pulse(entry_clr); idle(2);
    check("R4 exit direct", int'(cur_state), 5);
    check("R7 one wake", wakes, 1);
    frames(2);
    check("R4 back to inactive", int'(cur_state), 1);
    // R3 boundary: programmed count above the floor
    idle_prog = 4'd8;
    pulse(entry_set);
    frames(7);
    check("R3 seven of eight", int'(cur_state), 1);
    frames(1);
    check("R3 eighth frame", int'(cur_state), 2);
    // R8: disable waits out the transition
    pulse(dis_req); idle(3);
    check("R8 held in transition", int'(cur_state), 2);
    frames(2);
    idle(2);
    check("R8 off after transition", int'(cur_state), 0);
    check("R8 sfu cleared", int'(sfu_pending), 0);
    pulse(en_set); idle(2);
    frames(10);
    check("R8 entry cleared by disable", int'(cur_state), 1);
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule